// File: doc/BRIEF.md
# Interrupt Line Redirection Arbiter

This block sits between a bank of hardware interrupt request lines and a local interrupt controller. Each line owns a redirection entry holding the vector to deliver, a mask, a trigger-mode selector and a destination byte. Software reaches the entries through a two-register window: an index register picks one 32-bit half of one entry, and a data register reads or writes that half.

A rising edge on a line that is unmasked and set to edge mode becomes a pending request for that line. Lines set to level mode and masked lines never become pending. Pending requests are drained one at a time through a valid/ready message port that carries the vector. When several are pending, the largest vector goes first. A line's pending bit clears only when the local side accepts its message.

Back-pressure rules: a transfer happens on a clock edge where `msg_valid` and `msg_ready` are both high. Once `msg_valid` rises it stays high, and `msg_vector` does not change, until that transfer. A request with higher priority that arrives meanwhile waits for the next offer. While `msg_ready` is held high, pending requests leave at one per cycle.

Top module: `ioredir_top`

## Requirements
- R1: After reset every entry reads low half 0x00010000 (masked, edge mode, vector 0) and high half 0. The index reads 0, nothing is pending and `msg_valid` is low.
- R2: With `reg_sel`=0 the port accesses the index register. It holds `reg_wdata[7:0]` and reads back zero-extended. With `reg_sel`=1 it accesses the half selected by the index: index bit 0 picks the half (0 low, 1 high) and index bits 7:1 pick the line. For an index past the last line, reads return 0 and writes change nothing.
- R3: Low-half layout: vector in bits 7:0, trigger mode in bit 15 (1 = level), mask in bit 16 (1 = masked). High-half layout: destination in bits 31:24. All other bits read 0. For example, a low write of 0x48D1 reads back 0xD1.
- R4: A line that is low on one sampled edge and high on the next becomes pending only if its entry is unmasked and in edge mode at that edge. Edges on masked lines or level-mode lines are discarded. A line held high makes no further request.
- R5: A second edge on a line that is already pending merges into the existing request. It yields one message.
- R6: The message carries the vector of the offered line. Among pending, unmasked, edge-mode lines, the largest vector is offered first.
- R7: Once `msg_valid` is high it stays high with a stable `msg_vector` until accepted, even if a higher-priority request arrives.
- R8: Acceptance clears the offered line's pending bit. An edge on that line in the accepting cycle makes it pending again and produces one more message.
- R9: With `msg_ready` held high, the requests pending at that time leave on consecutive cycles in priority order.
- R10: On an idle block, a line sampled high at edge k after being low gives `msg_valid` high after edge k+1 and not before.
- R11: A pending line that gets masked before it is offered is held back, not dropped. It is delivered after it is unmasked. A message already being offered is not withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | N_LINES | Hardware interrupt request lines |
| reg_sel | input | 1 | 0 selects the index register, 1 selects the data register |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| msg_valid | output | 1 | A vector message is offered |
| msg_vector | output | 8 | Vector of the offered message |
| msg_ready | input | 1 | The local controller accepts the offered message |

## Verification
Some properties are checked on every cycle: the hold-and-stable rule of the message port under back-pressure, that an offered line is still pending, that a masked or level-mode line never becomes pending, that the chosen vector is at least as large as every other eligible one, and that out-of-range writes leave entries untouched. Other behaviours only the bench scenarios can show. These are the exact two-edge latency, the re-arm of a line whose edge coincides with its own acceptance, the merging of repeated edges, holding back a masked pending request until it is unmasked, and the full drain order and back-to-back timing across random vector, mask and mode settings.

// File: rtl/ioredir_pkg.sv
package ioredir_pkg;
  localparam int VEC_W       = 8;
  localparam int DEST_W      = 8;
  localparam int WORD_W      = 32;
  localparam int IDX_W       = 8;
  localparam int LO_TRIG_BIT = 15;
  localparam int LO_MASK_BIT = 16;
  localparam int HI_DEST_LSB = WORD_W - DEST_W;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              level;
    logic [VEC_W-1:0]  vector;
  } redir_ent_t;

  localparam redir_ent_t ENT_RESET = '{dest: '0, mask: 1'b1, level: 1'b0, vector: '0};

  function automatic logic [WORD_W-1:0] pack_lo(input redir_ent_t e);
    logic [WORD_W-1:0] w;
    w = '0;
    w[VEC_W-1:0]  = e.vector;
    w[LO_TRIG_BIT] = e.level;
    w[LO_MASK_BIT] = e.mask;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_hi(input redir_ent_t e);
    logic [WORD_W-1:0] w;
    w = '0;
    w[WORD_W-1:HI_DEST_LSB] = e.dest;
    return w;
  endfunction
endpackage

// File: rtl/ioredir_regfile.sv
module ioredir_regfile
  import ioredir_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_sel,
  input  logic                     reg_we,
  input  logic [WORD_W-1:0]        reg_wdata,
  output logic [WORD_W-1:0]        reg_rdata,
  output logic [N_LINES-1:0]       mask_o,
  output logic [N_LINES-1:0]       level_o,
  output logic [N_LINES*VEC_W-1:0] vec_o
);
  localparam int LINE_W = IDX_W - 1;

  logic [IDX_W-1:0]  idx_q;
  redir_ent_t        ent_q [N_LINES];
  logic [LINE_W-1:0] sel_line;
  logic              in_range;
  logic              data_we;
  logic [WORD_W-1:0] data_rd;

  assign sel_line = idx_q[IDX_W-1:1];
  assign in_range = (sel_line < LINE_W'(N_LINES));
  assign data_we  = reg_we && reg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (reg_we && !reg_sel) idx_q <= reg_wdata[IDX_W-1:0];
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= ENT_RESET;
      end else if (data_we && in_range && sel_line == LINE_W'(g)) begin
        if (idx_q[0]) begin
          ent_q[g].dest <= reg_wdata[WORD_W-1:HI_DEST_LSB];
        end else begin
          ent_q[g].vector <= reg_wdata[VEC_W-1:0];
          ent_q[g].level  <= reg_wdata[LO_TRIG_BIT];
          ent_q[g].mask   <= reg_wdata[LO_MASK_BIT];
        end
      end
    end
    assign mask_o[g]                 = ent_q[g].mask;
    assign level_o[g]                = ent_q[g].level;
    assign vec_o[g*VEC_W +: VEC_W]   = ent_q[g].vector;
  end

  always_comb begin
    data_rd = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (in_range && sel_line == LINE_W'(i))
        data_rd = idx_q[0] ? pack_hi(ent_q[i]) : pack_lo(ent_q[i]);
    end
  end

  assign reg_rdata = reg_sel ? data_rd : {{(WORD_W-IDX_W){1'b0}}, idx_q};

  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    data_we && !in_range |=> $stable(vec_o) && $stable(mask_o) && $stable(level_o)); // R2
endmodule

// File: rtl/ioredir_edge_capture.sv
module ioredir_edge_capture #(
  parameter int N_LINES = 8,
  parameter int LINE_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic [N_LINES-1:0] level_i,
  input  logic               clr_en_i,
  input  logic [LINE_W-1:0]  clr_line_i,
  output logic [N_LINES-1:0] pend_o
);
  logic [N_LINES-1:0] prev_q;
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] rise;
  logic [N_LINES-1:0] take;
  logic [N_LINES-1:0] clr_vec;

  assign rise = irq_i & ~prev_q;
  assign take = rise & ~mask_i & ~level_i;

  always_comb begin
    clr_vec = '0;
    if (clr_en_i) clr_vec[clr_line_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= irq_i;
      pend_q <= (pend_q & ~clr_vec) | take;
    end
  end

  assign pend_o = pend_q;

  for (genvar g = 0; g < N_LINES; g++) begin : g_chk
    AST_BLOCKED_LINE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q[g] && (mask_i[g] || level_i[g]) |=> !pend_q[g]); // R4
  end
endmodule

// File: rtl/ioredir_pick.sv
module ioredir_pick #(
  parameter int N_LINES = 8,
  parameter int LINE_W  = 3,
  parameter int VEC_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_LINES-1:0]       elig_i,
  input  logic [N_LINES*VEC_W-1:0] vec_i,
  output logic                     found_o,
  output logic [LINE_W-1:0]        line_o,
  output logic [VEC_W-1:0]         vec_o
);
  always_comb begin
    found_o = 1'b0;
    line_o  = '0;
    vec_o   = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (elig_i[i] && (!found_o || vec_i[i*VEC_W +: VEC_W] > vec_o)) begin
        found_o = 1'b1;
        line_o  = LINE_W'(i);
        vec_o   = vec_i[i*VEC_W +: VEC_W];
      end
    end
  end

  AST_WINNER_IS_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> elig_i[line_o]); // R6

  for (genvar g = 0; g < N_LINES; g++) begin : g_chk
    AST_WINNER_NOT_BEATEN: assert property (@(posedge clk) disable iff (!rst_n)
      found_o && elig_i[g] |-> vec_i[g*VEC_W +: VEC_W] <= vec_o); // R6
  end
endmodule

// File: rtl/ioredir_top.sv
module ioredir_top
  import ioredir_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic               reg_sel,
  input  logic               reg_we,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               msg_valid,
  output logic [7:0]         msg_vector,
  input  logic               msg_ready
);
  localparam int LINE_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  logic [N_LINES-1:0]       mask;
  logic [N_LINES-1:0]       level;
  logic [N_LINES*VEC_W-1:0] vecs;
  logic [N_LINES-1:0]       pend;
  logic [N_LINES-1:0]       elig;
  logic [N_LINES-1:0]       excl;
  logic                     found;
  logic [LINE_W-1:0]        win_line;
  logic [VEC_W-1:0]         win_vec;
  logic                     out_valid_q;
  logic [LINE_W-1:0]        out_line_q;
  logic [VEC_W-1:0]         out_vec_q;
  logic                     accept;
  logic                     load;

  ioredir_regfile #(.N_LINES(N_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mask_o(mask), .level_o(level), .vec_o(vecs)
  );

  ioredir_edge_capture #(.N_LINES(N_LINES), .LINE_W(LINE_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_lines), .mask_i(mask), .level_i(level),
    .clr_en_i(accept), .clr_line_i(out_line_q), .pend_o(pend)
  );

  assign accept = out_valid_q && msg_ready;
  assign load   = !out_valid_q || accept;

  always_comb begin
    excl = '0;
    if (accept) excl[out_line_q] = 1'b1;
  end

  assign elig = pend & ~mask & ~level & ~excl;

  ioredir_pick #(.N_LINES(N_LINES), .LINE_W(LINE_W), .VEC_W(VEC_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .elig_i(elig), .vec_i(vecs),
    .found_o(found), .line_o(win_line), .vec_o(win_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_line_q  <= '0;
      out_vec_q   <= '0;
    end else if (load) begin
      out_valid_q <= found;
      out_line_q  <= win_line;
      out_vec_q   <= win_vec;
    end
  end

  assign msg_valid  = out_valid_q;
  assign msg_vector = out_vec_q;

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector)); // R7

  AST_OFFER_STILL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> pend[out_line_q]); // R8

  AST_NO_OFFER_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(|pend)); // R10
endmodule

// File: tb/ioredir_top_bench.sv
`timescale 1ns/1ps
module ioredir_top_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic         reg_sel = 1'b0;
  logic         reg_we = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         msg_valid;
  logic [7:0]   msg_vector;
  logic         msg_ready = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];
  int first_hit;
  int last_hit;

  logic [7:0] m_vec [N];
  bit         m_mask[N];
  bit         m_lvl [N];

  always #2 clk = ~clk;

  ioredir_top #(.N_LINES(N)) u_ioredir_top (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
    .msg_vector(msg_vector), .msg_ready(msg_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input bit sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] lo_word(input logic [7:0] v, input bit lvl, input bit msk);
    return {15'd0, msk, lvl, 7'd0, v};
  endfunction

  task automatic set_lo(input int line, input logic [7:0] v, input bit lvl, input bit msk);
    wr(1'b0, 32'(2*line));
    wr(1'b1, lo_word(v, lvl, msk));
    m_vec[line] = v; m_lvl[line] = lvl; m_mask[line] = msk;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain(input int cyc);
    got_q.delete();
    first_hit = -1; last_hit = -1;
    @(negedge clk);
    msg_ready = 1'b1;
    for (int c = 0; c < cyc; c++) begin
      #1;
      if (msg_valid) begin
        got_q.push_back(msg_vector);
        if (first_hit < 0) first_hit = c;
        last_hit = c;
      end
      @(negedge clk);
    end
    msg_ready = 1'b0;
  endtask

  function automatic void model_order(input logic [N-1:0] raised);
    bit taken[N];
    exp_q.delete();
    for (int i = 0; i < N; i++) taken[i] = 0;
    for (int k = 0; k < N; k++) begin
      int best = -1;
      for (int i = 0; i < N; i++) begin
        if (raised[i] && !m_mask[i] && !m_lvl[i] && !taken[i]) begin
          if (best < 0 || m_vec[i] > m_vec[best]) best = i;
        end
      end
      if (best >= 0) begin
        taken[best] = 1;
        exp_q.push_back(m_vec[best]);
      end
    end
  endfunction

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [N-1:0] raised;
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < N; i++) begin m_vec[i] = 0; m_mask[i] = 1; m_lvl[i] = 0; end
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(1'b0, d); chk("R1 index", d, 32'h0);
    rd(1'b1, d); chk("R1 low half", d, 32'h00010000);
    wr(1'b0, 32'h1); rd(1'b1, d); chk("R1 high half", d, 32'h0);
    chk("R1 no valid", {31'd0, msg_valid}, 32'h0);

    // R2 index register and range
    wr(1'b0, 32'h1234ABCD); rd(1'b0, d); chk("R2 index readback", d, 32'hCD);
    wr(1'b0, 32'(2*N)); rd(1'b1, d); chk("R2 out of range read", d, 32'h0);
    wr(1'b1, 32'hFFFFFFFF); rd(1'b1, d); chk("R2 out of range write", d, 32'h0);
    wr(1'b0, 32'(2*N-2)); rd(1'b1, d); chk("R2 last line untouched", d, 32'h00010000);

    // R3 field layout
    wr(1'b0, 32'h2); wr(1'b1, 32'h000048D1); rd(1'b1, d); chk("R3 low vector", d, 32'h000000D1);
    wr(1'b0, 32'h3); wr(1'b1, 32'h01000000); rd(1'b1, d); chk("R3 high dest", d, 32'h01000000);
    wr(1'b1, 32'hFFFFFFFF); rd(1'b1, d); chk("R3 high unused", d, 32'hFF000000);
    wr(1'b0, 32'h2); wr(1'b1, 32'hFFFFFFFF); rd(1'b1, d); chk("R3 low unused", d, 32'h000180FF);
    set_lo(1, 8'h00, 0, 1);

    // R10 latency
    set_lo(0, 8'h41, 0, 0);
    @(negedge clk); irq[0] = 1'b1;
    @(negedge clk); #1 chk("R10 not after one edge", {31'd0, msg_valid}, 32'h0);
    @(negedge clk); #1 chk("R10 valid after two edges", {31'd0, msg_valid}, 32'h1);
    chk("R6 vector", {24'd0, msg_vector}, 32'h41);
    drain(4); chk("R8 single delivery", got_q.size(), 1);

    // R4 held line, masked, level
    idle(4); chk("R4 held high no repeat", {31'd0, msg_valid}, 32'h0);
    @(negedge clk); irq[1] = 1'b1; idle(4);
    chk("R4 masked edge dropped", {31'd0, msg_valid}, 32'h0);
    set_lo(1, 8'h77, 0, 0); idle(4);
    chk("R4 unmask without edge", {31'd0, msg_valid}, 32'h0);
    set_lo(2, 8'h88, 1, 0);
    @(negedge clk); irq[2] = 1'b1; idle(4);
    chk("R4 level line dropped", {31'd0, msg_valid}, 32'h0);
    @(negedge clk); irq = '0; idle(2);

    // R11 mask holds back a pending line; R6 priority
    set_lo(3, 8'h50, 0, 0); set_lo(4, 8'h60, 0, 0);
    @(negedge clk); irq[3] = 1'b1; irq[4] = 1'b1; idle(3);
    chk("R6 larger vector first", {24'd0, msg_vector}, 32'h60);
    set_lo(3, 8'h50, 0, 1);
    drain(6);
    chk("R11 masked held back count", got_q.size(), 1);
    if (got_q.size() > 0) chk("R11 offered not withdrawn", {24'd0, got_q[0]}, 32'h60);
    set_lo(3, 8'h50, 0, 0); idle(3);
    chk("R11 delivered after unmask", {23'd0, msg_valid, msg_vector}, 32'h150);
    drain(4);
    @(negedge clk); irq = '0; idle(2);

    // R7 back-pressure
    set_lo(5, 8'h30, 0, 0); set_lo(6, 8'h90, 0, 0);
    @(negedge clk); irq[5] = 1'b1; idle(3);
    @(negedge clk); irq[6] = 1'b1; idle(3);
    chk("R7 offer held", {23'd0, msg_valid, msg_vector}, 32'h130);
    drain(5);
    chk("R7 count", got_q.size(), 2);
    if (got_q.size() == 2) begin
      chk("R7 first", {24'd0, got_q[0]}, 32'h30);
      chk("R7 second", {24'd0, got_q[1]}, 32'h90);
    end

    // R5 merge
    @(negedge clk); irq[5] = 1'b0;
    @(negedge clk); irq[5] = 1'b1;
    @(negedge clk); irq[5] = 1'b0;
    @(negedge clk); irq[5] = 1'b1;
    idle(3); drain(5);
    chk("R5 merged into one", got_q.size(), 1);

    // R8 edge in accepting cycle re-arms
    @(negedge clk); irq = '0; idle(2);
    @(negedge clk); irq[6] = 1'b1; idle(3);
    @(negedge clk); irq[6] = 1'b0;
    @(negedge clk); msg_ready = 1'b1; irq[6] = 1'b1;
    @(negedge clk); msg_ready = 1'b0;
    @(negedge clk); #1;
    chk("R8 re-armed offer", {23'd0, msg_valid, msg_vector}, 32'h190);
    drain(4); chk("R8 one more message", got_q.size(), 1);
    @(negedge clk); irq = '0; idle(2);

    // random rounds: R6, R9, R4
    for (int r = 0; r < 25; r++) begin
      for (int i = 0; i < N; i++)
        set_lo(i, 8'($urandom), ($urandom % 5) == 0, ($urandom % 4) == 0);
      raised = N'($urandom);
      @(negedge clk); irq = raised;
      idle(3);
      @(negedge clk); irq = '0;
      model_order(raised);
      drain(N + 3);
      chk("R6 random count", got_q.size(), exp_q.size());
      for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
        chk("R6 random order", {24'd0, got_q[k]}, {24'd0, exp_q[k]});
      if (got_q.size() > 0) begin
        chk("R9 back-to-back start", first_hit, 0);
        chk("R9 back-to-back end", last_hit, got_q.size() - 1);
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule